// File: doc/BRIEF.md
# Packet Transmit Queue with Retry Lockout

This block is the transmit-side buffer of one network port. A host pushes one 32-bit double word per clock. Beside each word the queue stores the four active-low byte-valid strobes, an end-of-packet tag and the packet's no-CRC request. A MAC transmitter on the drain side sees the head entry and removes it with a pop strobe. A space-ready flag tells the host when the number of free slots has reached a programmable threshold.

The MAC reports failed attempts through event inputs. A late collision, lost or missing carrier, a drain underrun in the middle of a packet, or a run of sixteen collisions without a successful send each latch a sticky retry flag. While that flag is set the queue stays empty, host writes are thrown away and space-ready stays low. The host must then clear the flag with a clear pulse while this port is selected, and rewrite the packet.

Top module: `txq_port`

## Requirements
- R1: After synchronous reset the queue is empty (`rd_valid` low), `retry` and `ovfl` are low, and `space_rdy` reflects a fully free queue.
- R2: A word is stored only in a cycle where `host_sel` is high and both `tx_if_en_n` and `tx_wr_en_n` are low. Words leave in write order. The head shows the stored data, byte enables and end-of-packet tag.
- R3: The queue holds DEPTH (default 32) words. A write attempted while the queue is full is dropped and sets `ovfl`, which stays high until reset.
- R4: `space_rdy` is high exactly when the number of free slots is greater than or equal to `thresh` and `retry` is low. It is updated the cycle after the write or pop that changes the fill.
- R5: `wr_nocrc` is sampled only on the first word of a packet. That is a word written after reset, after a flush, or after a word tagged end-of-packet. Every word of the packet then carries that value on `rd_nocrc`.
- R6: `retry` is set the cycle after any of these: `ev_late_col`, `ev_no_carrier`, or a pop while empty after the drain has taken a non-final word of a packet.
- R7: While `retry` is high the queue is held empty, `rd_valid` and `space_rdy` are low, and writes are ignored. A write in the same cycle as a failure event is also dropped.
- R8: `retry` falls only after a cycle with `clr_txerr` and `host_sel` both high. A clear pulse without `host_sel` has no effect. If a failure event and a clear fall in the same cycle, the set wins.
- R9: A write and a pop in the same cycle, on a queue that is neither empty nor full, leave the fill unchanged. A pop on an empty queue between packets has no effect.
- R10: The COLL_LIMIT-th `ev_coll` pulse (default 16) since reset, the last `ev_tx_ok` or the last retry sets `retry`. An `ev_tx_ok` pulse restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | This port is the one the host addresses |
| tx_if_en_n | input | 1 | Transmit interface enable, active low |
| tx_wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 32 | Double word to store |
| wr_be_n | input | 4 | Byte-valid strobes, active low |
| wr_eop | input | 1 | Marks the last word of a packet |
| wr_nocrc | input | 1 | No-CRC request, taken on the first word of a packet |
| thresh | input | 6 | Free-slot threshold in double words |
| space_rdy | output | 1 | Free slots >= threshold and not in retry |
| ovfl | output | 1 | Sticky dropped-write indication |
| rd_valid | output | 1 | Head entry present |
| rd_data | output | 32 | Head data |
| rd_be_n | output | 4 | Head byte-valid strobes |
| rd_eop | output | 1 | Head end-of-packet tag |
| rd_nocrc | output | 1 | No-CRC request of the head packet |
| rd_pop | input | 1 | Remove the head entry |
| ev_late_col | input | 1 | Late collision event |
| ev_no_carrier | input | 1 | Carrier absent or lost event |
| ev_coll | input | 1 | One collision on an attempt |
| ev_tx_ok | input | 1 | Packet sent without error |
| clr_txerr | input | 1 | Clear pulse for the retry flag |
| retry | output | 1 | Sticky retry lockout flag |

## Verification
Two kinds of same-cycle overlap get dedicated tests. The first is a push and a pop together: it must leave the fill as it was. The bench sets the threshold one below the depth, so the result shows on `space_rdy`, and it reads the new head word. The second is a failure event in the same cycle as a host write. The bench drives both on one clock. After the clear it checks that the queue is empty and that neither the written word nor any older word comes back on the drain side.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int TXQ_DW   = 32;
    localparam int TXQ_BE_W = TXQ_DW / 8;

    typedef struct packed {
        logic                eop;
        logic                nocrc;
        logic [TXQ_BE_W-1:0] be_n;
        logic [TXQ_DW-1:0]   data;
    } txq_entry_t;

    function automatic logic [15:0] txq_free(input logic [15:0] depth,
                                             input logic [15:0] fill);
        return depth - fill;
    endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store
    import txq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  txq_entry_t    din,
    output txq_entry_t    dout,
    output logic [CW-1:0] fill,
    output logic          empty,
    output logic          full
);

    txq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign fill  = cnt;
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

endmodule

// File: rtl/txq_frame.sv
module txq_frame (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic push,
    input  logic push_eop,
    input  logic wr_nocrc,
    output logic entry_nocrc,
    input  logic pop,
    input  logic pop_eop,
    input  logic pop_req,
    input  logic empty,
    output logic underflow
);

    logic wr_in_pkt, nocrc_q, rd_in_pkt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_in_pkt <= 1'b0;
            nocrc_q   <= 1'b0;
        end else if (push) begin
            if (!wr_in_pkt) nocrc_q <= wr_nocrc;
            wr_in_pkt <= !push_eop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush)
            rd_in_pkt <= 1'b0;
        else if (pop)
            rd_in_pkt <= !pop_eop;
    end

    assign entry_nocrc = wr_in_pkt ? nocrc_q : wr_nocrc;
    assign underflow   = pop_req && empty && rd_in_pkt;

endmodule

// File: rtl/txq_retry.sv
module txq_retry #(
    parameter int COLL_LIMIT = 16,
    localparam int CCW = $clog2(COLL_LIMIT + 1)
)(
    input  logic clk,
    input  logic rst,
    input  logic ev_late_col,
    input  logic ev_no_carrier,
    input  logic underflow,
    input  logic ev_coll,
    input  logic ev_tx_ok,
    input  logic clr,
    output logic set_now,
    output logic retry
);

    logic [CCW-1:0] coll_cnt;
    logic           coll_hit;
    logic           retry_q;

    assign coll_hit = ev_coll && (coll_cnt == CCW'(COLL_LIMIT - 1));
    assign set_now  = ev_late_col || ev_no_carrier || underflow || coll_hit;

    always_ff @(posedge clk) begin
        if (rst || set_now || ev_tx_ok)
            coll_cnt <= '0;
        else if (ev_coll)
            coll_cnt <= coll_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          retry_q <= 1'b0;
        else if (set_now) retry_q <= 1'b1;
        else if (clr)     retry_q <= 1'b0;
    end

    assign retry = retry_q;

endmodule

// File: rtl/txq_port.sv
module txq_port
    import txq_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int COLL_LIMIT = 16,
    localparam int CW = $clog2(DEPTH + 1)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_sel,
    input  logic                tx_if_en_n,
    input  logic                tx_wr_en_n,
    input  logic [TXQ_DW-1:0]   wr_data,
    input  logic [TXQ_BE_W-1:0] wr_be_n,
    input  logic                wr_eop,
    input  logic                wr_nocrc,
    input  logic [CW-1:0]       thresh,
    output logic                space_rdy,
    output logic                ovfl,
    output logic                rd_valid,
    output logic [TXQ_DW-1:0]   rd_data,
    output logic [TXQ_BE_W-1:0] rd_be_n,
    output logic                rd_eop,
    output logic                rd_nocrc,
    input  logic                rd_pop,
    input  logic                ev_late_col,
    input  logic                ev_no_carrier,
    input  logic                ev_coll,
    input  logic                ev_tx_ok,
    input  logic                clr_txerr,
    output logic                retry
);

    txq_entry_t    din, dout;
    logic [CW-1:0] fill;
    logic [15:0]   free16;
    logic          empty, full, flush, set_now, underflow;
    logic          wr_try, push, pop, entry_nocrc, ovfl_q;

    assign wr_try = host_sel && !tx_if_en_n && !tx_wr_en_n;
    assign flush  = retry || set_now;
    assign push   = wr_try && !full && !flush;
    assign pop    = rd_pop && !empty && !flush;

    assign din.data  = wr_data;
    assign din.be_n  = wr_be_n;
    assign din.eop   = wr_eop;
    assign din.nocrc = entry_nocrc;

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(pop),
        .din(din), .dout(dout), .fill(fill), .empty(empty), .full(full)
    );

    txq_frame u_frame (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .push_eop(wr_eop),
        .wr_nocrc(wr_nocrc), .entry_nocrc(entry_nocrc), .pop(pop),
        .pop_eop(dout.eop), .pop_req(rd_pop), .empty(empty),
        .underflow(underflow)
    );

    txq_retry #(.COLL_LIMIT(COLL_LIMIT)) u_retry (
        .clk(clk), .rst(rst), .ev_late_col(ev_late_col),
        .ev_no_carrier(ev_no_carrier), .underflow(underflow),
        .ev_coll(ev_coll), .ev_tx_ok(ev_tx_ok),
        .clr(clr_txerr && host_sel), .set_now(set_now), .retry(retry)
    );

    always_ff @(posedge clk) begin
        if (rst)                             ovfl_q <= 1'b0;
        else if (wr_try && full && !flush)   ovfl_q <= 1'b1;
    end

    assign free16    = txq_free(16'(DEPTH), 16'(fill));
    assign space_rdy = !retry && (free16 >= 16'(thresh));
    assign ovfl      = ovfl_q;
    assign rd_valid  = !empty && !retry;
    assign rd_data   = dout.data;
    assign rd_be_n   = dout.be_n;
    assign rd_eop    = dout.eop;
    assign rd_nocrc  = dout.nocrc;

endmodule

// File: rtl/txq_port_chk.sv
module txq_port_chk #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
)(
    input logic          clk,
    input logic          rst,
    input logic          host_sel,
    input logic          tx_if_en_n,
    input logic          tx_wr_en_n,
    input logic          rd_pop,
    input logic          ev_late_col,
    input logic          ev_no_carrier,
    input logic          clr_txerr,
    input logic          retry,
    input logic          ovfl,
    input logic          space_rdy,
    input logic          rd_valid,
    input logic [CW-1:0] fill
);

    logic wr_try;
    assign wr_try = host_sel && !tx_if_en_n && !tx_wr_en_n;

    // R3: a write on a full queue with no pop is dropped and flagged
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_try && !rd_pop && fill == CW'(DEPTH) && !retry
         && !ev_late_col && !ev_no_carrier)
        |=> (ovfl && (retry || fill == CW'(DEPTH))));

    // R3: overflow indication is sticky
    p_ovfl_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ovfl |=> ovfl);

    // R7: lockout keeps the queue empty and the host flags low
    p_lockout_empty_r7: assert property (@(posedge clk) disable iff (rst)
        retry |-> (fill == '0 && !rd_valid && !space_rdy));

    // R8: retry only falls after a selected clear
    p_retry_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (retry && !(clr_txerr && host_sel)) |=> retry);

    // R6: late collision or carrier loss raises retry next cycle
    p_event_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_late_col || ev_no_carrier) |=> retry);

    // R9: simultaneous push and pop keep the fill
    p_pushpop_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_try && rd_pop && fill != '0 && fill != CW'(DEPTH) && !retry
         && !ev_late_col && !ev_no_carrier)
        |=> (retry || $stable(fill)));

endmodule

bind txq_port txq_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .host_sel(host_sel), .tx_if_en_n(tx_if_en_n),
    .tx_wr_en_n(tx_wr_en_n), .rd_pop(rd_pop), .ev_late_col(ev_late_col),
    .ev_no_carrier(ev_no_carrier), .clr_txerr(clr_txerr), .retry(retry),
    .ovfl(ovfl), .space_rdy(space_rdy), .rd_valid(rd_valid), .fill(fill)
);

// File: tb/txq_port_bench.sv
module txq_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b1, tx_if_en_n = 1'b0, tx_wr_en_n = 1'b1;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be_n = '0;
    logic        wr_eop = 1'b0, wr_nocrc = 1'b0;
    logic [5:0]  thresh = 6'd8;
    logic        space_rdy, ovfl, rd_valid, rd_eop, rd_nocrc, retry;
    logic [31:0] rd_data;
    logic [3:0]  rd_be_n;
    logic        rd_pop = 1'b0;
    logic        ev_late_col = 1'b0, ev_no_carrier = 1'b0;
    logic        ev_coll = 1'b0, ev_tx_ok = 1'b0, clr_txerr = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    txq_port u_txq_port (
        .clk(clk), .rst(rst), .host_sel(host_sel), .tx_if_en_n(tx_if_en_n),
        .tx_wr_en_n(tx_wr_en_n), .wr_data(wr_data), .wr_be_n(wr_be_n),
        .wr_eop(wr_eop), .wr_nocrc(wr_nocrc), .thresh(thresh),
        .space_rdy(space_rdy), .ovfl(ovfl), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_be_n(rd_be_n), .rd_eop(rd_eop),
        .rd_nocrc(rd_nocrc), .rd_pop(rd_pop), .ev_late_col(ev_late_col),
        .ev_no_carrier(ev_no_carrier), .ev_coll(ev_coll),
        .ev_tx_ok(ev_tx_ok), .clr_txerr(clr_txerr), .retry(retry)
    );

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic s, input logic ifn, input logic [31:0] d,
                        input logic [3:0] be, input logic e, input logic nc);
        host_sel = s; tx_if_en_n = ifn; tx_wr_en_n = 1'b0;
        wr_data = d; wr_be_n = be; wr_eop = e; wr_nocrc = nc;
        @(negedge clk);
        tx_wr_en_n = 1'b1; host_sel = 1'b1; tx_if_en_n = 1'b0;
    endtask

    task automatic pop1();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic clear(input logic s);
        host_sel = s; clr_txerr = 1'b1;
        @(negedge clk);
        clr_txerr = 1'b0; host_sel = 1'b1;
    endtask

    task automatic t_reset();
        thresh = 6'd8;
        do_reset();
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 retry", 64'(retry), 64'd0);
        chk("R1 ovfl", 64'(ovfl), 64'd0);
        chk("R1 space_rdy", 64'(space_rdy), 64'd1);
    endtask

    task automatic t_order();
        do_reset();
        push(1, 0, 32'h1111_1111, 4'b0000, 0, 0);
        push(1, 0, 32'h2222_2222, 4'b1100, 0, 0);
        push(1, 0, 32'h3333_3333, 4'b0111, 1, 0);
        push(0, 0, 32'hBAD0_0001, 4'b0000, 1, 0);
        push(1, 1, 32'hBAD0_0002, 4'b0000, 1, 0);
        chk("R2 head0 data", 64'(rd_data), 64'h1111_1111);
        chk("R2 head0 eop", 64'(rd_eop), 64'd0);
        pop1();
        chk("R2 head1 data", 64'(rd_data), 64'h2222_2222);
        chk("R2 head1 be_n", 64'(rd_be_n), 64'hC);
        pop1();
        chk("R2 head2 data", 64'(rd_data), 64'h3333_3333);
        chk("R2 head2 be_n", 64'(rd_be_n), 64'h7);
        chk("R2 head2 eop", 64'(rd_eop), 64'd1);
        pop1();
        chk("R2 gated writes not stored", 64'(rd_valid), 64'd0);
        pop1();
        chk("R9 idle pop on empty no retry", 64'(retry), 64'd0);
    endtask

    task automatic t_full();
        thresh = 6'd4;
        do_reset();
        for (int i = 0; i < 28; i++)
            push(1, 0, 32'hA000_0000 + 32'(i), 4'h0, 1, 0);
        chk("R4 free 4 thr 4", 64'(space_rdy), 64'd1);
        push(1, 0, 32'hA000_0000 + 32'd28, 4'h0, 1, 0);
        chk("R4 free 3 thr 4", 64'(space_rdy), 64'd0);
        for (int i = 29; i < 32; i++)
            push(1, 0, 32'hA000_0000 + 32'(i), 4'h0, 1, 0);
        chk("R3 no ovfl at exactly full", 64'(ovfl), 64'd0);
        push(1, 0, 32'hDEAD_BEEF, 4'h0, 1, 0);
        chk("R3 ovfl on full write", 64'(ovfl), 64'd1);
        for (int i = 0; i < 32; i++) begin
            chk("R3 drain order", 64'(rd_data), 64'(32'hA000_0000 + 32'(i)));
            pop1();
        end
        chk("R3 dropped word absent", 64'(rd_valid), 64'd0);
        chk("R3 ovfl sticky", 64'(ovfl), 64'd1);
        chk("R4 empty thr 4", 64'(space_rdy), 64'd1);
        thresh = 6'd8;
    endtask

    task automatic t_nocrc();
        do_reset();
        push(1, 0, 32'h0000_00A0, 4'h0, 0, 1);
        push(1, 0, 32'h0000_00A1, 4'h0, 1, 0);
        push(1, 0, 32'h0000_00B0, 4'h0, 0, 0);
        push(1, 0, 32'h0000_00B1, 4'h0, 1, 1);
        chk("R5 pkt A first", 64'(rd_nocrc), 64'd1);
        pop1();
        chk("R5 pkt A second keeps", 64'(rd_nocrc), 64'd1);
        pop1();
        chk("R5 pkt B first", 64'(rd_nocrc), 64'd0);
        pop1();
        chk("R5 pkt B later ignored", 64'(rd_nocrc), 64'd0);
        pop1();
    endtask

    task automatic t_simul();
        thresh = 6'd31;
        do_reset();
        push(1, 0, 32'h5555_0001, 4'h0, 1, 0);
        chk("R4 free 31 thr 31", 64'(space_rdy), 64'd1);
        rd_pop = 1'b1;
        push(1, 0, 32'h5555_0002, 4'h0, 1, 0);
        rd_pop = 1'b0;
        chk("R9 push+pop fill kept", 64'(space_rdy), 64'd1);
        chk("R9 push+pop new head", 64'(rd_data), 64'h5555_0002);
        pop1();
        chk("R9 empty after drain", 64'(rd_valid), 64'd0);
        thresh = 6'd8;
    endtask

    // kind 0: late collision, 1: carrier loss, 2: underrun
    task automatic t_retry(input int kind);
        do_reset();
        push(1, 0, 32'h7000_0001, 4'h0, 0, 0);
        push(1, 0, 32'h7000_0002, 4'h0, 0, 0);
        if (kind == 2) begin
            pop1();
            pop1();
            chk("R6 no retry before underrun", 64'(retry), 64'd0);
            pop1();
        end else begin
            if (kind == 0) ev_late_col = 1'b1;
            else           ev_no_carrier = 1'b1;
            push(1, 0, 32'h7000_0003, 4'h0, 1, 0);
            ev_late_col = 1'b0; ev_no_carrier = 1'b0;
        end
        chk("R6 retry set", 64'(retry), 64'd1);
        chk("R7 rd_valid low", 64'(rd_valid), 64'd0);
        chk("R7 space_rdy low", 64'(space_rdy), 64'd0);
        push(1, 0, 32'h7000_0004, 4'h0, 1, 0);
        chk("R7 write ignored", 64'(rd_valid), 64'd0);
        clear(1'b0);
        chk("R8 unselected clear ignored", 64'(retry), 64'd1);
        clear(1'b1);
        chk("R8 selected clear", 64'(retry), 64'd0);
        chk("R7 queue flushed", 64'(rd_valid), 64'd0);
        chk("R7 space_rdy back", 64'(space_rdy), 64'd1);
        push(1, 0, 32'h7000_0005, 4'h0, 1, 0);
        chk("R7 fresh word at head", 64'(rd_data), 64'h7000_0005);
    endtask

    task automatic t_coll();
        do_reset();
        ev_coll = 1'b1;
        repeat (15) @(negedge clk);
        ev_coll = 1'b0;
        chk("R10 15 collisions no retry", 64'(retry), 64'd0);
        ev_tx_ok = 1'b1;
        @(negedge clk);
        ev_tx_ok = 1'b0;
        ev_coll = 1'b1;
        repeat (15) @(negedge clk);
        ev_coll = 1'b0;
        chk("R10 count restarted by tx_ok", 64'(retry), 64'd0);
        ev_coll = 1'b1;
        @(negedge clk);
        ev_coll = 1'b0;
        chk("R10 16th collision sets retry", 64'(retry), 64'd1);
        ev_late_col = 1'b1; host_sel = 1'b1; clr_txerr = 1'b1;
        @(negedge clk);
        ev_late_col = 1'b0; clr_txerr = 1'b0;
        chk("R8 set wins over clear", 64'(retry), 64'd1);
        clear(1'b1);
        chk("R8 cleared after", 64'(retry), 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_nocrc();
        t_simul();
        for (int k = 0; k < 3; k++) t_retry(k);
        t_coll();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule